// File: doc/BRIEF.md
# 32-bit Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit RISC execute path. It takes a data word, a 5-bit shift count, a 3-bit shift-kind code and the current carry flag. In the same cycle it returns the shifted word and the carry that the shift produces. Four shift kinds take a count: logical left, logical right, arithmetic right and rotate right. A fifth kind rotates the word right by one place through the carry flag.

The block is purely combinational. It has no clock and no state. The datapath is five log-stage mux layers, one for each bit of the count. A guard bit travels alongside the word through every layer and ends up holding the last bit shifted out. Left shifts reuse the right-shifting layers by bit-reversing the word on the way in and on the way out.

Top module: `barrel_shift32`

## Requirements
- R1: Kind code 3'b000 (logical left by n) moves each bit n places toward bit 31 and clears the n lowest result bits.
- R2: Kind code 3'b001 (logical right by n) moves each bit n places toward bit 0 and clears the n highest result bits.
- R3: Kind code 3'b010 (arithmetic right by n) moves each bit n places toward bit 0 and fills the n highest result bits with operand bit 31.
- R4: Kind code 3'b011 (rotate right by n) returns bits that leave bit 0 into the top of the word, so result = (x >> n) | (x << (32-n)).
- R5: Kind code 3'b100 (rotate right through carry) ignores the count. The result is {carry_i, x[31:1]} and carry_o is x[0].
- R6: For codes 3'b000 to 3'b011 with a count n > 0, carry_o is operand bit (32-n) for the left shift, and operand bit (n-1) for the three right-going kinds.
- R7: For codes 3'b000 to 3'b011 with a count of 0, result_o equals operand_i and carry_o equals carry_i.
- R8: Codes 3'b101, 3'b110 and 3'b111 pass operand_i to result_o unchanged and pass carry_i to carry_o, for every count.
- R9: The outputs depend only on the present inputs. The block holds no state between input patterns, so a given input pattern always gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to be shifted |
| amount_i | input | 5 | Shift count, 0 to 31 |
| kind_i | input | 3 | Shift-kind code |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The bench sweeps every kind code against every count, using sign-bit, alternating, single-bit and pseudo-random words, and drives both values of the carry flag. The zero count is the main trap: a design that took carry_o from a shifted-out bit at n = 0 would corrupt the flag on every plain register move. The extremes 1 and 31 expose off-by-one carry indexing, with the left shift reading bit 32-n and the right-going kinds reading bit n-1. Negative operands catch an arithmetic shift that fills with zeros. The through-carry rotate and the unused codes catch a design that lets the count leak in or drops the incoming flag.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    K_LSL = 3'b000,
    K_LSR = 3'b001,
    K_ASR = 3'b010,
    K_ROR = 3'b011,
    K_RRX = 3'b100
  } shift_kind_e;
endpackage

// File: rtl/shift_stage.sv
// One log-stage layer: right-shift by S with fill or rotate, tracking the last bit out.
module shift_stage #(
  parameter int W = 32,
  parameter int S = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         g_i,
  input  logic         en_i,
  input  logic         rot_i,
  input  logic         fill_i,
  output logic [W-1:0] d_o,
  output logic         g_o
);
  logic [S-1:0] top_bits;
  assign top_bits = rot_i ? d_i[S-1:0] : {S{fill_i}};
  assign d_o = en_i ? {top_bits, d_i[W-1:S]} : d_i;
  assign g_o = en_i ? d_i[S-1] : g_i;
endmodule

// File: rtl/shift_core.sv
// Count-driven shifts (LSL/LSR/ASR/ROR) built from AMT_W right-shift layers.
module shift_core #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     x_i,
  input  logic [AMT_W-1:0] n_i,
  input  logic [1:0]       kind_i,
  input  logic             c_i,
  output logic [W-1:0]     y_o,
  output logic             c_o
);
  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) bit_rev[i] = v[W-1-i];
  endfunction

  logic is_left, is_rot, fill;
  assign is_left = (kind_i == 2'b00);
  assign is_rot  = (kind_i == 2'b11);
  assign fill    = (kind_i == 2'b10) ? x_i[W-1] : 1'b0;

  logic [W-1:0] d [AMT_W+1];
  logic         g [AMT_W+1];

  assign d[0] = is_left ? bit_rev(x_i) : x_i;
  assign g[0] = c_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_layer
    shift_stage #(.W(W), .S(1 << k)) u_stage (
      .d_i   (d[k]),
      .g_i   (g[k]),
      .en_i  (n_i[k]),
      .rot_i (is_rot),
      .fill_i(fill),
      .d_o   (d[k+1]),
      .g_o   (g[k+1])
    );
  end

  assign y_o = is_left ? bit_rev(d[AMT_W]) : d[AMT_W];
  assign c_o = g[AMT_W];

  always_comb begin
    if (is_rot) p_rot_keeps_ones_r4: assert ($countones(y_o) == $countones(x_i));
    if (kind_i == 2'b10) p_asr_sign_kept_r3: assert (y_o[W-1] == x_i[W-1]);
  end
endmodule

// File: rtl/barrel_shift32.sv
module barrel_shift32
  import shift_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [2:0]       kind_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o
);
  logic [W-1:0] core_y;
  logic         core_c;

  shift_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .x_i   (operand_i),
    .n_i   (amount_i),
    .kind_i(kind_i[1:0]),
    .c_i   (carry_i),
    .y_o   (core_y),
    .c_o   (core_c)
  );

  always_comb begin
    if (!kind_i[2]) begin
      result_o = core_y;
      carry_o  = core_c;
    end else if (kind_i == K_RRX) begin
      result_o = {carry_i, operand_i[W-1:1]};
      carry_o  = operand_i[0];
    end else begin
      result_o = operand_i;
      carry_o  = carry_i;
    end
  end

  always_comb begin
    if (!kind_i[2] && amount_i == '0)
      p_zero_count_pass_r7: assert (core_y == operand_i && core_c == carry_i);
    if (kind_i == K_RRX)
      p_rrx_carry_r5: assert (carry_o == operand_i[0] && result_o[W-1] == carry_i);
    if (kind_i[2] && kind_i[1:0] != 2'b00)
      p_unused_pass_r8: assert (result_o == operand_i && carry_o == carry_i);
  end
endmodule

// File: tb/sim_barrel_shift32.sv
module sim_barrel_shift32;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] op;
  logic [4:0]  amt;
  logic [2:0]  kind;
  logic        cin;
  logic [31:0] res;
  logic        cout;

  int n_run  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  barrel_shift32 u0 (
    .operand_i(op), .amount_i(amt), .kind_i(kind), .carry_i(cin),
    .result_o(res), .carry_o(cout)
  );

  function automatic string tag_of(input logic [2:0] k, input logic [4:0] n);
    if (k > 3'd4) return "R8";
    if (k == 3'd4) return "R5";
    if (n == 0) return "R7";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input logic [31:0] x, input logic [4:0] n,
                       input logic [2:0] k, input logic c);
    logic [31:0] er;
    logic        ec;
    int          ni;
    op = x; amt = n; kind = k; cin = c;
    @(negedge clk);
    ni = int'(n);
    er = x; ec = c;
    if (k == 3'd4) begin
      er = {c, x[31:1]}; ec = x[0];
    end else if (k < 3'd4 && ni > 0) begin
      case (k)
        3'd0: begin er = x << ni; ec = x[32-ni]; end
        3'd1: begin er = x >> ni; ec = x[ni-1]; end
        3'd2: begin er = 32'($signed(x) >>> ni); ec = x[ni-1]; end
        default: begin er = (x >> ni) | (x << (32 - ni)); ec = x[ni-1]; end
      endcase
    end
    n_run++;
    if (res !== er) begin
      n_fail++;
      $display("FAIL %s result k=%0d n=%0d x=%h: got %h exp %h", tag_of(k, n), k, n, x, res, er);
    end
    n_run++;
    if (cout !== ec) begin
      n_fail++;
      $display("FAIL %s carry (R6 when n>0) k=%0d n=%0d x=%h: got %b exp %b",
               tag_of(k, n), k, n, x, cout, ec);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [8];
    logic [31:0] lfsr;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
    pats[3] = 32'h0000_0001; pats[4] = 32'hAAAA_5555; pats[5] = 32'h7FFF_FFFE;
    pats[6] = 32'hC001_0F80; pats[7] = 32'h1234_5678;
    // first pattern: all-zero inputs give zero outputs (R1, R7)
    check(32'h0, 5'd0, 3'd0, 1'b0);
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 32; n++)
          for (int c = 0; c < 2; c++)
            check(pats[p], 5'(n), 3'(k), 1'(c));
    // pseudo-random words (R1..R8)
    lfsr = 32'hACE1_1234;
    for (int r = 0; r < 24; r++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 32; n++)
          check(lfsr, 5'(n), 3'(k), lfsr[7]);
    end
    // R9: returning to an earlier pattern gives the same outputs
    check(32'h8000_0000, 5'd31, 3'd2, 1'b0);
    check(32'h0000_0001, 5'd1, 3'd0, 1'b1);
    check(32'h8000_0000, 5'd31, 3'd2, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule